// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block connects a synchronous request/acknowledge host port to an external asynchronous static RAM of 4096 four-bit words. The RAM has one shared data bus, so the same wires carry write data into the RAM and read data out of it. The host offers a request while `req_ready` is high. A request is a read or a write, a 12-bit address, 4-bit write data, and a flag that selects how a write is shaped. The controller then drives the address lines and the active-low chip enable, write enable and output enable strobes. It also controls the enable that lets its write data onto the shared bus. The tri-state pad sits at the chip boundary.

Every strobe window is a whole number of clock cycles. These counts are worked out at elaboration from nanosecond timing parameters and the clock period in picoseconds. A different speed grade or clock therefore needs only new parameter values.

Two write shapes are offered:
- In a write-enable-shaped write, chip enable falls one cycle ahead of write enable. Write enable then rises one cycle ahead of chip enable, so write enable both opens and closes the write.
- In a chip-enable-shaped write, the order is mirrored, so chip enable opens and closes the write.

A read holds chip enable and output enable low for the access window. The controller samples the bus in the last cycle of that window and returns the word with a one-cycle valid pulse.

Top module: `sramc_ctrl`

## Requirements
- R1: While reset is asserted, at any point in an access, `ram_ce_n`, `ram_we_n` and `ram_oe_n` are 1, `ram_dq_oe` is 0 and `rsp_valid` is 0. Once reset is released, `req_ready` is 1.
- R2: `req_ready` is 1 only when no access is in progress. A request presented while `req_ready` is 0 is ignored: it starts no RAM access and changes no stored word.
- R3: A read holds `ram_ce_n`=0, `ram_oe_n`=0 and `ram_we_n`=1, with `ram_dq_oe`=0, for exactly RD_CYC consecutive cycles, starting in the cycle after acceptance.
- R4: `rsp_valid` is 1 for exactly one cycle, the one right after the last read access cycle. In that cycle `rsp_rdata` holds the word the RAM drove during the last access cycle.
- R5: A write with `req_ce_ctrl`=0 has four phases:
  - one lead cycle with `ram_ce_n`=0 and `ram_we_n`=1;
  - WR_CYC cycles with both strobes at 0;
  - one tail cycle with `ram_we_n`=1 and `ram_ce_n`=0;
  - a return to idle with all strobes at 1.
- R6: A write with `req_ce_ctrl`=1 has four phases:
  - one lead cycle with `ram_we_n`=0 and `ram_ce_n`=1;
  - WR_CYC cycles with both strobes at 0;
  - one tail cycle with `ram_ce_n`=1 and `ram_we_n`=0;
  - a return to idle.
- R7: During a write's strobe and tail cycles, `ram_dq_oe` is 1 and `ram_dq_out` equals the request's write data. During the lead cycle `ram_dq_oe` is 0. `ram_dq_oe` is never 1 while `ram_oe_n` is 0.
- R8: `ram_oe_n` is 0 only while `ram_ce_n` is 0 and `ram_we_n` is 1. `ram_dq_oe` is 0 in the cycle before any falling edge of `ram_oe_n`.
- R9: Cycle counts are derived as follows:
  - each window is ceil(ns*1000/CLK_PERIOD_PS) cycles, and 0 only for a 0 ns window;
  - RD_CYC is the larger of the read cycle count and the access count;
  - WR_CYC is the largest of the write cycle, chip-enable-to-end, address-to-end, pulse and data-setup counts, and at least 1.
  - With the defaults (4000 ps clock, 25 ns read, 20 ns write), RD_CYC=7 and WR_CYC=5.
- R10: `ram_addr` equals the accepted address and stays stable for the whole access.
- R11: A read returns the word most recently written to that address, with either write shape, including addresses 0x000 and 0xFFF and an overwritten word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ce_ctrl | input | 1 | Write shape: 1 = chip-enable-shaped, 0 = write-enable-shaped |
| req_addr | input | 12 | Word address |
| req_wdata | input | 4 | Write data |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| rsp_valid | output | 1 | One-cycle read-data valid pulse |
| rsp_rdata | output | 4 | Read data |
| ram_addr | output | 12 | RAM address lines |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_dq_out | output | 4 | Data toward the shared bus |
| ram_dq_oe | output | 1 | Bus driver enable for `ram_dq_out` |
| ram_dq_in | input | 4 | Data sampled from the shared bus |

## Verification
The main check compares the strobe waveform cycle by cycle with the expected phases for each kind of access:
- Reads are tried against write-enable-shaped writes and chip-enable-shaped writes. This distinguishes which strobe leads and which strobe trails.
- Addresses 0x000, 0xFFF, 0x555 and 0xAAA, with complementary data, would expose stuck or swapped address and data bits.
- Overwriting a single address with one write shape after the other shows that the later write wins.
- A request held during a busy read shows whether the busy controller starts an access it should ignore.
- A reset asserted in the middle of a write strobe shows whether the strobes are released at once.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_LEAD,
    ST_STRB,
    ST_TAIL
  } sramc_state_e;

  // Ceiling of a nanosecond window over the clock period; zero stays zero.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ps);
    if (ns == 0) return 0;
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned floor1(input int unsigned a);
    return (a == 0) ? 1 : a;
  endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sramc_fsm.sv
module sramc_fsm
  import sramc_pkg::*;
#(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned RD_CYC   = 7,
  parameter int unsigned WR_CYC   = 5,
  parameter int unsigned LEAD_CYC = 1,
  parameter int unsigned TAIL_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_ce_ctrl,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             idle,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             drive
);
  sramc_state_e st_q, st_d;
  logic         ce_mode_q;

  assign idle   = (st_q == ST_IDLE);
  assign accept = idle && req_valid;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        if (req_write) begin
          st_d    = ST_LEAD;
          tmr_val = CNT_W'(LEAD_CYC - 1);
        end else begin
          st_d    = ST_READ;
          tmr_val = CNT_W'(RD_CYC - 1);
        end
      end
      ST_READ: if (tmr_done) begin
        st_d    = ST_IDLE;
        capture = 1'b1;
      end
      ST_LEAD: if (tmr_done) begin
        st_d     = ST_STRB;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WR_CYC - 1);
      end
      ST_STRB: if (tmr_done) begin
        st_d     = ST_TAIL;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(TAIL_CYC - 1);
      end
      ST_TAIL: if (tmr_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      ce_mode_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept && req_write) ce_mode_q <= req_ce_ctrl;
    end
  end

  // Strobe decode: the lead and tail cycles open and close the write with one strobe.
  always_comb begin
    ce_n  = 1'b1;
    we_n  = 1'b1;
    oe_n  = 1'b1;
    drive = 1'b0;
    case (st_q)
      ST_READ: begin
        ce_n = 1'b0;
        oe_n = 1'b0;
      end
      ST_LEAD: begin
        if (ce_mode_q) we_n = 1'b0;
        else           ce_n = 1'b0;
      end
      ST_STRB: begin
        ce_n  = 1'b0;
        we_n  = 1'b0;
        drive = 1'b1;
      end
      ST_TAIL: begin
        if (ce_mode_q) we_n = 1'b0;
        else           ce_n = 1'b0;
        drive = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rvalid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= dq_in;
    end
  end
endmodule

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int unsigned ADDR_W        = 12,
  parameter int unsigned DATA_W        = 4,
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned T_RC_NS       = 25,
  parameter int unsigned T_AA_NS       = 25,
  parameter int unsigned T_WC_NS       = 20,
  parameter int unsigned T_CW_NS       = 20,
  parameter int unsigned T_AW_NS       = 20,
  parameter int unsigned T_WP_NS       = 20,
  parameter int unsigned T_DW_NS       = 10,
  parameter int unsigned T_AS_NS       = 0,
  parameter int unsigned T_AH_NS       = 0,
  parameter int unsigned T_DH_NS       = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_ce_ctrl,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);
  localparam int unsigned RD_CYC = floor1(max2(ns_to_cyc(T_RC_NS, CLK_PERIOD_PS),
                                              ns_to_cyc(T_AA_NS, CLK_PERIOD_PS)));
  localparam int unsigned WR_CYC = floor1(max2(max2(ns_to_cyc(T_WC_NS, CLK_PERIOD_PS),
                                                    ns_to_cyc(T_CW_NS, CLK_PERIOD_PS)),
                                               max2(max2(ns_to_cyc(T_AW_NS, CLK_PERIOD_PS),
                                                         ns_to_cyc(T_WP_NS, CLK_PERIOD_PS)),
                                                    ns_to_cyc(T_DW_NS, CLK_PERIOD_PS))));
  localparam int unsigned LEAD_CYC = floor1(ns_to_cyc(T_AS_NS, CLK_PERIOD_PS));
  localparam int unsigned TAIL_CYC = floor1(max2(ns_to_cyc(T_AH_NS, CLK_PERIOD_PS),
                                                 ns_to_cyc(T_DH_NS, CLK_PERIOD_PS)));
  localparam int unsigned MAX_CYC  = max2(max2(RD_CYC, WR_CYC), max2(LEAD_CYC, TAIL_CYC));
  localparam int unsigned CNT_W    = $clog2(MAX_CYC) + 1;

  // Internal events brought out by name for the bound checker.
  logic             acc_evt;
  logic             cap_evt;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic             idle;

  sramc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sramc_fsm #(
    .CNT_W    (CNT_W),
    .RD_CYC   (RD_CYC),
    .WR_CYC   (WR_CYC),
    .LEAD_CYC (LEAD_CYC),
    .TAIL_CYC (TAIL_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_ce_ctrl (req_ce_ctrl),
    .tmr_done    (tmr_done),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .accept      (acc_evt),
    .capture     (cap_evt),
    .idle        (idle),
    .ce_n        (ram_ce_n),
    .we_n        (ram_we_n),
    .oe_n        (ram_oe_n),
    .drive       (ram_dq_oe)
  );

  sramc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (acc_evt),
    .capture   (cap_evt),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_in     (ram_dq_in),
    .addr_q    (ram_addr),
    .wdata_q   (ram_dq_out),
    .rdata_q   (rsp_rdata),
    .rvalid_q  (rsp_valid)
  );

  assign req_ready = idle;
endmodule

// File: rtl/sramc_checker.sv
module sramc_checker #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned WR_CYC = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ram_ce_n,
  input logic              ram_we_n,
  input logic              ram_oe_n,
  input logic              ram_dq_oe,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              req_ready,
  input logic              rsp_valid
);
  logic       both_low;
  logic [7:0] run_q;

  assign both_low = !ram_ce_n && !ram_we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (both_low) run_q <= run_q + 8'd1;
    else               run_q <= '0;
  end

  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_oe_n |-> (!ram_ce_n && ram_we_n && !ram_dq_oe)); // R8

  AST_BUS_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_oe_n) |-> !$past(ram_dq_oe)); // R8

  AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> (ram_oe_n && (!ram_ce_n || !ram_we_n))); // R7

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R4

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_ce_n && ram_we_n && ram_oe_n && !ram_dq_oe)); // R2

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> $stable(ram_addr)); // R10

  AST_WRITE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(both_low) && !both_low) |-> (run_q == 8'(WR_CYC))); // R9
endmodule

bind sramc_ctrl sramc_checker #(.ADDR_W(ADDR_W), .WR_CYC(WR_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ram_ce_n  (ram_ce_n),
  .ram_we_n  (ram_we_n),
  .ram_oe_n  (ram_oe_n),
  .ram_dq_oe (ram_dq_oe),
  .ram_addr  (ram_addr),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid)
);

// File: tb/sramc_ctrl_test.sv
`timescale 1ns/1ps
module sramc_ctrl_test;
  localparam int PER_PS = 4000;
  localparam int RD_EXP = (25 * 1000 + PER_PS - 1) / PER_PS;  // 7, R9
  localparam int WR_EXP = (20 * 1000 + PER_PS - 1) / PER_PS;  // 5, R9

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_ce_ctrl = 1'b0;
  logic [11:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [3:0]  rsp_rdata;
  logic [11:0] ram_addr;
  logic        ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe;
  logic [3:0]  ram_dq_out, ram_dq_in;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sramc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ce_ctrl(req_ce_ctrl), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  // Behavioural RAM: stores while both strobes are low, drives only in a read.
  logic [3:0] mem [4096];
  initial for (int i = 0; i < 4096; i++) mem[i] = 4'h0;
  always @(posedge clk)
    if (!ram_ce_n && !ram_we_n && ram_dq_oe) mem[ram_addr] <= ram_dq_out;
  assign ram_dq_in = (!ram_ce_n && !ram_oe_n && ram_we_n) ? mem[ram_addr] : 4'h0;

  // {write, ce_shaped, addr[11:0], data[3:0]}; for reads data is the expected word
  localparam int NV = 14;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b0, 12'h000, 4'h5},
    {1'b1, 1'b1, 12'hFFF, 4'hA},
    {1'b0, 1'b0, 12'h000, 4'h5},
    {1'b0, 1'b0, 12'hFFF, 4'hA},
    {1'b1, 1'b0, 12'h555, 4'hF},
    {1'b1, 1'b1, 12'hAAA, 4'h0},
    {1'b0, 1'b0, 12'h555, 4'hF},
    {1'b0, 1'b0, 12'hAAA, 4'h0},
    {1'b1, 1'b1, 12'h123, 4'h3},
    {1'b1, 1'b0, 12'h123, 4'hC},
    {1'b0, 1'b0, 12'h123, 4'hC},
    {1'b1, 1'b0, 12'h800, 4'h6},
    {1'b1, 1'b1, 12'h800, 4'h9},
    {1'b0, 1'b0, 12'h800, 4'h9}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic cem, input logic [11:0] a, input logic [3:0] d);
    @(negedge clk);
    chk(req_ready === 1'b1, "R2 ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_ce_ctrl = cem; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
  endtask

  task automatic do_read(input logic [11:0] a, input logic [3:0] exp);
    int good = 0;
    issue(1'b0, 1'b0, a, 4'h0);
    for (int k = 0; k < RD_EXP; k++) begin
      if (k > 0) @(negedge clk);
      if (!ram_ce_n && !ram_oe_n && ram_we_n && !ram_dq_oe && ram_addr == a && !req_ready && !rsp_valid)
        good++;
    end
    chk(good == RD_EXP, "R3/R10 read strobe window", good, RD_EXP);
    @(negedge clk);
    chk(rsp_valid && ram_ce_n && ram_oe_n, "R4 valid after window", int'(rsp_valid), 1);
    chk(rsp_rdata == exp, "R11 read data", int'(rsp_rdata), int'(exp));
    @(negedge clk);
    chk(!rsp_valid, "R4 single pulse", int'(rsp_valid), 0);
  endtask

  task automatic do_write(input logic cem, input logic [11:0] a, input logic [3:0] d);
    int good = 0;
    issue(1'b1, cem, a, d);
    if (cem) chk(ram_ce_n && !ram_we_n && ram_oe_n && !ram_dq_oe, "R6 lead cycle",
                 {ram_ce_n, ram_we_n, ram_dq_oe}, 3'b100);
    else     chk(!ram_ce_n && ram_we_n && ram_oe_n && !ram_dq_oe, "R5 lead cycle",
                 {ram_ce_n, ram_we_n, ram_dq_oe}, 3'b010);
    for (int k = 0; k < WR_EXP; k++) begin
      @(negedge clk);
      if (!ram_ce_n && !ram_we_n && ram_oe_n && ram_dq_oe && ram_dq_out == d && ram_addr == a)
        good++;
    end
    chk(good == WR_EXP, "R9/R7 write strobe width and data", good, WR_EXP);
    @(negedge clk);
    if (cem) chk(ram_ce_n && !ram_we_n && ram_dq_oe && ram_dq_out == d, "R6 tail cycle",
                 {ram_ce_n, ram_we_n, ram_dq_oe}, 3'b101);
    else     chk(!ram_ce_n && ram_we_n && ram_dq_oe && ram_dq_out == d, "R5 tail cycle",
                 {ram_ce_n, ram_we_n, ram_dq_oe}, 3'b011);
    @(negedge clk);
    chk(ram_ce_n && ram_we_n && ram_oe_n && !ram_dq_oe && req_ready, "R8 bus released at idle",
        {ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe}, 4'b1110);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(ram_ce_n && ram_we_n && ram_oe_n && !ram_dq_oe && !rsp_valid, "R1 strobes in reset",
        {ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe, rsp_valid}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready after reset", int'(req_ready), 1);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][17]) do_write(VEC[v][16], VEC[v][15:4], VEC[v][3:0]);
      else            do_read(VEC[v][15:4], VEC[v][3:0]);
    end

    // R2: request while busy is ignored
    do_write(1'b0, 12'h321, 4'h9);
    issue(1'b0, 1'b0, 12'h000, 4'h0);
    req_valid = 1'b1; req_write = 1'b1; req_ce_ctrl = 1'b0; req_addr = 12'h321; req_wdata = 4'h1;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    begin
      int quiet = 0;
      for (int k = 0; k < 4; k++) begin
        if (ram_ce_n && ram_we_n) quiet++;
        @(negedge clk);
      end
      chk(quiet == 4, "R2 no access from busy request", quiet, 4);
    end
    do_read(12'h321, 4'h9);  // R2: stored word unchanged

    // R1: reset in the middle of a write strobe
    issue(1'b1, 1'b0, 12'h044, 4'h7);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    chk(ram_ce_n && ram_we_n && ram_oe_n && !ram_dq_oe && !rsp_valid, "R1 mid-write reset",
        {ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe}, 4'b1110);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready after second reset", int'(req_ready), 1);
    do_read(12'hFFF, 4'hA);  // R11: contents survive controller reset

    finish_run();
  end
endmodule